// File: doc/BRIEF.md
# CAN Controller Status Word

This block holds the eight-bit, read-only status word of a CAN controller. The protocol engine reports activity to it through one-cycle strobes: transmit start and end, transmit success, receive start and end, a strobe when a received message begins to be stored, and bus-off entry and exit. The engine also supplies the live values of the transmit and receive error counters. The CPU side drives three command strobes: request transmission, release the receive buffer, and clear the overrun flag.

Inside, the block tracks how many of the two receive buffer slots hold a message, and whether the single transmit buffer is locked. Two flags come from these trackers and are not independent sticky bits. The overrun flag is raised when a message must be stored while both slots are full. The buffer-access flag follows the transmit buffer lock. The CPU reads the word through a small register port: a read is registered and returns data one cycle later. Writes to the word are ignored.

Top module: `can_stat_reg`

## Requirements
- R1: After a synchronous reset, the status word reads 0x0C. This means bus-on, no error warning, transmitter and receiver idle, transmission complete set, transmit buffer released, no overrun and no message.
- R2: The bit layout is fixed, from bit 7 down to bit 0: bus-off, error warning, transmitting, receiving, transmission complete, transmit buffer released, data overrun, message available.
- R3: A read strobe at the status address returns the word on `cpu_rdata` one cycle later. A read of any other address returns 0, and `cpu_rdata` is 0 in the cycle after any cycle with no read. A write to any address, the status address included, leaves the word unchanged.
- R4: A bus-off entry strobe sets bit 7 and clears bits 5 and 4. A bus-off exit strobe clears bit 7.
- R5: Bit 6 is 1 when either error counter is greater than or equal to WARN_LIMIT (default 96), and 0 when both are below it. It follows the counters one clock later.
- R6: Bit 5 is set by transmit start and cleared by transmit end. Bit 4 is set by receive start and cleared by receive end.
- R7: A transmit request made while the buffer is released clears bit 3 and bit 2 on the same clock edge.
- R8: A transmit success strobe while the buffer is locked sets bit 3 and bit 2 again. A transmit request while the buffer is locked has no effect.
- R9: A store strobe with a free slot takes the message, and bit 0 reads 1 while at least one slot is occupied.
- R10: A release command frees the older slot. Bit 0 stays 1 while the other slot still holds a message, and returns to 0 when both slots are empty.
- R11: A store strobe while both slots are full drops the message and sets bit 1. Bit 1 then stays set until a clear-overrun command.
- R12: A release and a store in the same cycle with both slots full are treated release first. The new message is taken and bit 1 is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_tx_start | input | 1 | Engine started sending a frame |
| ev_tx_end | input | 1 | Engine stopped sending (success or not) |
| ev_tx_ok | input | 1 | Requested frame sent successfully |
| ev_rx_start | input | 1 | Engine started receiving a frame |
| ev_rx_end | input | 1 | Engine finished receiving |
| ev_rx_store | input | 1 | First byte of a received message must be stored |
| ev_bus_off | input | 1 | Controller entered bus-off |
| ev_bus_on | input | 1 | Controller left bus-off |
| tx_err_cnt | input | CNT_W | Transmit error counter value |
| rx_err_cnt | input | CNT_W | Receive error counter value |
| cmd_tx_req | input | 1 | CPU transmit request |
| cmd_rx_release | input | 1 | CPU release receive buffer |
| cmd_clr_overrun | input | 1 | CPU clear overrun flag |
| cpu_addr | input | ADDR_W | Register address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe (ignored by this word) |
| cpu_wdata | input | 8 | Write data (ignored) |
| cpu_rdata | output | 8 | Registered read data |

## Verification
The assertions check, on every cycle, the rules that hold at all times. The receive slot count never exceeds the depth, and overrun stays set until it is cleared. A locked transmit buffer stays locked until a success strobe, and completion is never reported while the buffer is locked. An accepted request locks the buffer, bus-off entry is reflected at once, a warning-level counter raises the error bit, and idle or foreign-address reads return zero. Only the bench's scenarios can show the behaviour that depends on a sequence of events. These include the release-first ordering of a store and a release in the same cycle when both slots are full, the message bit staying set after one of two releases, and the exact byte values read back after writes.

// File: rtl/can_stat_pkg.sv
package can_stat_pkg;

    localparam int STAT_W = 8;

    // Field order is the software-visible bit layout (MSB first).
    typedef struct packed {
        logic bus_off;
        logic err_warn;
        logic tx_act;
        logic rx_act;
        logic tx_done;
        logic tx_free;
        logic overrun;
        logic rx_full;
    } stat_t;

    localparam stat_t STAT_RESET = '{
        bus_off:  1'b0,
        err_warn: 1'b0,
        tx_act:   1'b0,
        rx_act:   1'b0,
        tx_done:  1'b1,
        tx_free:  1'b1,
        overrun:  1'b0,
        rx_full:  1'b0
    };

    typedef struct packed {
        logic tx_start;
        logic tx_end;
        logic tx_ok;
        logic rx_start;
        logic rx_end;
        logic rx_store;
        logic bus_off;
        logic bus_on;
    } engine_ev_t;

    typedef struct packed {
        logic tx_req;
        logic rx_release;
        logic clr_overrun;
    } cpu_cmd_t;

    function automatic logic [STAT_W-1:0] stat_to_byte(input stat_t s);
        return s;
    endfunction

endpackage

// File: rtl/can_stat_txtrk.sv
module can_stat_txtrk (
    input  logic clk,
    input  logic rst,
    input  logic tx_req,
    input  logic tx_ok,
    output logic tx_done,
    output logic tx_free
);
    logic done_q, free_q;
    logic accept, finish;

    // A request is only taken while the buffer is released.
    assign accept = tx_req && free_q;
    assign finish = tx_ok && !free_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b1;
            free_q <= 1'b1;
        end else if (accept) begin
            done_q <= 1'b0;
            free_q <= 1'b0;
        end else if (finish) begin
            done_q <= 1'b1;
            free_q <= 1'b1;
        end
    end

    assign tx_done = done_q;
    assign tx_free = free_q;

    assert_req_locks_R7: assert property (@(posedge clk) disable iff (rst)
        (tx_req && free_q) |=> (!free_q && !done_q));

    assert_lock_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (!free_q && !tx_ok) |=> !free_q);

    assert_done_only_free_R8: assert property (@(posedge clk) disable iff (rst)
        !(done_q && !free_q));

endmodule

// File: rtl/can_stat_rxtrk.sv
module can_stat_rxtrk #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic store,
    input  logic release_buf,
    input  logic clr_overrun,
    output logic rx_full,
    output logic overrun
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] cnt_q, after_rel, cnt_n;
    logic          ovr_q, rel, take, drop;

    // Release is applied first, so it can make room for a store in the same cycle.
    assign rel       = release_buf && (cnt_q != '0);
    assign after_rel = cnt_q - CW'(rel);
    assign take      = store && (after_rel < CW'(DEPTH));
    assign drop      = store && !take;
    assign cnt_n     = after_rel + CW'(take);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ovr_q <= 1'b0;
        end else begin
            cnt_q <= cnt_n;
            if (drop)
                ovr_q <= 1'b1;
            else if (clr_overrun)
                ovr_q <= 1'b0;
        end
    end

    assign rx_full = (cnt_q != '0);
    assign overrun = ovr_q;

    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

    assert_ovr_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        (ovr_q && !clr_overrun) |=> ovr_q);

    assert_full_store_ovr_R11: assert property (@(posedge clk) disable iff (rst)
        (store && !release_buf && cnt_q == CW'(DEPTH)) |=> ovr_q);

endmodule

// File: rtl/can_stat_link.sv
module can_stat_link #(
    parameter int CNT_W = 8,
    parameter int NCNT  = 2,
    parameter int WARN  = 96
) (
    input  logic                      clk,
    input  logic                      rst,
    input  can_stat_pkg::engine_ev_t  ev,
    input  logic [NCNT-1:0][CNT_W-1:0] cnt_vec,
    output logic                      bus_off,
    output logic                      err_warn,
    output logic                      tx_act,
    output logic                      rx_act
);
    logic [NCNT-1:0] hit;
    logic bus_q, err_q, tx_q, rx_q;

    for (genvar i = 0; i < NCNT; i++) begin : g_cmp
        assign hit[i] = (cnt_vec[i] >= CNT_W'(WARN));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_q <= 1'b0;
            err_q <= 1'b0;
            tx_q  <= 1'b0;
            rx_q  <= 1'b0;
        end else begin
            err_q <= |hit;
            if (ev.bus_off)
                bus_q <= 1'b1;
            else if (ev.bus_on)
                bus_q <= 1'b0;
            if (ev.bus_off || ev.tx_end)
                tx_q <= 1'b0;
            else if (ev.tx_start)
                tx_q <= 1'b1;
            if (ev.bus_off || ev.rx_end)
                rx_q <= 1'b0;
            else if (ev.rx_start)
                rx_q <= 1'b1;
        end
    end

    assign bus_off  = bus_q;
    assign err_warn = err_q;
    assign tx_act   = tx_q;
    assign rx_act   = rx_q;

    assert_busoff_R4: assert property (@(posedge clk) disable iff (rst)
        ev.bus_off |=> (bus_q && !tx_q && !rx_q));

    assert_warn_R5: assert property (@(posedge clk) disable iff (rst)
        (cnt_vec[0] >= CNT_W'(WARN)) |=> err_q);

    assert_txact_R6: assert property (@(posedge clk) disable iff (rst)
        (ev.tx_start && !ev.tx_end && !ev.bus_off) |=> tx_q);

endmodule

// File: rtl/can_stat_reg.sv
module can_stat_reg #(
    parameter int          ADDR_W      = 4,
    parameter logic [3:0]  STAT_ADDR   = 4'h6,
    parameter int          CNT_W       = 8,
    parameter int          WARN_LIMIT  = 96,
    parameter int          RX_DEPTH    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_tx_start,
    input  logic              ev_tx_end,
    input  logic              ev_tx_ok,
    input  logic              ev_rx_start,
    input  logic              ev_rx_end,
    input  logic              ev_rx_store,
    input  logic              ev_bus_off,
    input  logic              ev_bus_on,
    input  logic [CNT_W-1:0]  tx_err_cnt,
    input  logic [CNT_W-1:0]  rx_err_cnt,
    input  logic              cmd_tx_req,
    input  logic              cmd_rx_release,
    input  logic              cmd_clr_overrun,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata
);
    import can_stat_pkg::*;

    localparam int NCNT = 2;

    engine_ev_t                  ev;
    cpu_cmd_t                    cmd;
    logic [NCNT-1:0][CNT_W-1:0]  cnts;
    stat_t                       stat;
    logic [7:0]                  rdata_q;
    logic                        hit_addr;

    // The word has no writable field; write strobes are absorbed here.
    logic unused_wr_path;
    assign unused_wr_path = ^{cpu_wr, cpu_wdata};

    assign ev = '{tx_start: ev_tx_start, tx_end: ev_tx_end, tx_ok: ev_tx_ok,
                  rx_start: ev_rx_start, rx_end: ev_rx_end, rx_store: ev_rx_store,
                  bus_off: ev_bus_off, bus_on: ev_bus_on};
    assign cmd = '{tx_req: cmd_tx_req, rx_release: cmd_rx_release,
                   clr_overrun: cmd_clr_overrun};
    assign cnts = {rx_err_cnt, tx_err_cnt};

    can_stat_link #(
        .CNT_W (CNT_W),
        .NCNT  (NCNT),
        .WARN  (WARN_LIMIT)
    ) u_link (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .cnt_vec  (cnts),
        .bus_off  (stat.bus_off),
        .err_warn (stat.err_warn),
        .tx_act   (stat.tx_act),
        .rx_act   (stat.rx_act)
    );

    can_stat_txtrk u_tx (
        .clk     (clk),
        .rst     (rst),
        .tx_req  (cmd.tx_req),
        .tx_ok   (ev.tx_ok),
        .tx_done (stat.tx_done),
        .tx_free (stat.tx_free)
    );

    can_stat_rxtrk #(
        .DEPTH (RX_DEPTH)
    ) u_rx (
        .clk         (clk),
        .rst         (rst),
        .store       (ev.rx_store),
        .release_buf (cmd.rx_release),
        .clr_overrun (cmd.clr_overrun),
        .rx_full     (stat.rx_full),
        .overrun     (stat.overrun)
    );

    assign hit_addr = (cpu_addr == ADDR_W'(STAT_ADDR));

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= 8'h00;
        else if (cpu_rd && hit_addr)
            rdata_q <= stat_to_byte(stat);
        else
            rdata_q <= 8'h00;
    end

    assign cpu_rdata = rdata_q;

    assert_other_read_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (!cpu_rd || !hit_addr) |=> (cpu_rdata == 8'h00));

    assert_read_layout_R2: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && hit_addr) |=> (cpu_rdata[3] == $past(stat.tx_done) &&
                                  cpu_rdata[0] == $past(stat.rx_full)));

endmodule

// File: tb/can_stat_reg_tb_top.sv
module can_stat_reg_tb_top;

    localparam logic [3:0] SADDR = 4'h6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic ev_tx_start = 0, ev_tx_end = 0, ev_tx_ok = 0;
    logic ev_rx_start = 0, ev_rx_end = 0, ev_rx_store = 0;
    logic ev_bus_off = 0, ev_bus_on = 0;
    logic [7:0] tx_err_cnt = 0, rx_err_cnt = 0;
    logic cmd_tx_req = 0, cmd_rx_release = 0, cmd_clr_overrun = 0;
    logic [3:0] cpu_addr = 0;
    logic cpu_rd = 0, cpu_wr = 0;
    logic [7:0] cpu_wdata = 0;
    logic [7:0] cpu_rdata;

    can_stat_reg dut_i (
        .clk(clk), .rst(rst),
        .ev_tx_start(ev_tx_start), .ev_tx_end(ev_tx_end), .ev_tx_ok(ev_tx_ok),
        .ev_rx_start(ev_rx_start), .ev_rx_end(ev_rx_end), .ev_rx_store(ev_rx_store),
        .ev_bus_off(ev_bus_off), .ev_bus_on(ev_bus_on),
        .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt),
        .cmd_tx_req(cmd_tx_req), .cmd_rx_release(cmd_rx_release),
        .cmd_clr_overrun(cmd_clr_overrun),
        .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 0;
    bit         done = 0;

    // Monitor: a read taken at a rising edge is compared at the next falling edge.
    always @(posedge clk) rd_seen <= cpu_rd;

    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (cpu_rdata !== e) begin
                n_bad++;
                $display("FAIL %s: got 0x%02h expected 0x%02h", t, cpu_rdata, e);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // Driver: issue one read and push what the requirements predict.
    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
        cpu_addr = a;
        cpu_rd   = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        cpu_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic chk(input logic [7:0] e, input string t);
        rd(SADDR, e, t);
    endtask

    task automatic step();
        @(negedge clk);
        ev_tx_start = 0; ev_tx_end = 0; ev_tx_ok = 0;
        ev_rx_start = 0; ev_rx_end = 0; ev_rx_store = 0;
        ev_bus_off = 0; ev_bus_on = 0;
        cmd_tx_req = 0; cmd_rx_release = 0; cmd_clr_overrun = 0;
        cpu_wr = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        chk(8'h0C, "R1 reset value");

        cpu_addr = SADDR; cpu_wr = 1; cpu_wdata = 8'hFF; step();
        chk(8'h0C, "R3 write ignored");
        rd(4'h3, 8'h00, "R3 other address reads zero");

        cmd_tx_req = 1; step();
        chk(8'h00, "R7 request locks and clears complete");
        cmd_tx_req = 1; step();
        chk(8'h00, "R8 request while locked ignored");
        ev_tx_start = 1; step();
        chk(8'h20, "R6 transmitting");
        ev_tx_ok = 1; step();
        chk(8'h2C, "R8 success releases");
        ev_tx_end = 1; step();
        chk(8'h0C, "R6 transmit idle");

        ev_rx_start = 1; step();
        chk(8'h1C, "R6 receiving");
        ev_rx_end = 1; ev_rx_store = 1; step();
        chk(8'h0D, "R9 message available");
        ev_rx_store = 1; step();
        chk(8'h0D, "R9 second slot");
        ev_rx_store = 1; step();
        chk(8'h0F, "R11 overrun on full");
        cmd_rx_release = 1; step();
        chk(8'h0F, "R10 second slot still holds");
        cmd_rx_release = 1; step();
        chk(8'h0E, "R10 both slots free, R11 overrun sticky");
        cmd_clr_overrun = 1; step();
        chk(8'h0C, "R11 overrun cleared");

        ev_rx_store = 1; step();
        ev_rx_store = 1; step();
        ev_rx_store = 1; cmd_rx_release = 1; step();
        chk(8'h0D, "R12 release first, no overrun");
        cmd_rx_release = 1; step();
        chk(8'h0D, "R12 taken message still held");
        cmd_rx_release = 1; step();
        chk(8'h0C, "R12 drained");

        tx_err_cnt = 8'd95; step();
        chk(8'h0C, "R5 below limit");
        tx_err_cnt = 8'd96; step();
        chk(8'h4C, "R5 at limit");
        tx_err_cnt = 8'd0; rx_err_cnt = 8'd200; step();
        chk(8'h4C, "R5 receive counter above limit");
        rx_err_cnt = 8'd95; step();
        chk(8'h0C, "R5 both below limit");

        ev_tx_start = 1; ev_rx_start = 1; step();
        chk(8'h3C, "R6 both active");
        ev_bus_off = 1; step();
        chk(8'h8C, "R4 bus-off clears activity");
        ev_bus_on = 1; step();
        chk(8'h0C, "R4 bus-on");

        ev_bus_off = 1; ev_rx_store = 1; tx_err_cnt = 8'd120; step();
        chk(8'hCD, "R2 combined layout");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R3: got %0d pending reads expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule